// File: doc/BRIEF.md
# Single-Bit Feedback Integrating Converter

This block sequences an integrating analog-to-digital conversion built from an external comparator, a one-bit feedback driver and an RC filter. In each iteration the block samples the comparator once. It drives the feedback bit high when the input is above the filtered feedback, and low when it is below. Over a conversion it counts all iterations and the iterations that drove feedback upward. The upward count divided by the total count is the input as a fraction of the supply, so the measurement is ratiometric.

Each iteration lasts a fixed number of clocks whatever the decision, so the feedback duty cycle depends only on the decisions. A conversion ends when the iteration counter carries out of its `RES_BITS`-wide range. An optional precharge phase can run before counting: it drives the feedback from the comparator for a set number of iterations and does not accumulate, so the filter has settled near the input when counting begins. After completion the feedback bit is left low, and the result register holds its value until the next completion.

Top module: `fbk_integ_conv`

## Requirements
- R1: After reset, `fb_o`, `done_o` and `result_o` are all zero.
- R2: Every iteration lasts exactly `ITER_CLKS` clocks, and `fb_o` can rise only at the single decision slot of an iteration.
- R3: `cmp_i` = 1 means the input is above the feedback. At each decision, `fb_o` takes the synchronized comparator level: 1 drives the feedback up, and 0 drives it down.
- R4: `done_o` rises exactly `(P + 2^RES_BITS) * ITER_CLKS` clocks after the edge that accepts `start_i`. P is `PRE_ITERS` when `precharge_i` was high with the start, and 0 otherwise.
- R5: `result_o` equals the number of counting iterations whose decision was 1, clamped to `2^RES_BITS - 1`. A comparator held at 0 gives 0, and one held at 1 gives the maximum.
- R6: `result_o` changes only in the cycle in which `done_o` is high.
- R7: `done_o` is a one-cycle pulse.
- R8: `fb_o` is 0 whenever no conversion is running, including the cycle of `done_o`.
- R9: Precharge iterations drive `fb_o` from the comparator but do not contribute to the result.
- R10: A `start_i` that arrives while a conversion is running is ignored. This includes a start that falls on the completing edge. The running conversion's timing does not change.
- R11: In closed loop with an RC-like filter, a constant input at a fraction x of full scale yields a result within 8 counts of x * 2^RES_BITS. A mid-scale input gives about half the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Comparator output, asynchronous; 1 = input above feedback |
| start_i | input | 1 | Starts a conversion when idle |
| precharge_i | input | 1 | Sampled with start; 1 adds the precharge phase |
| fb_o | output | 1 | Feedback drive bit; 1 drives the filter up |
| done_o | output | 1 | One-cycle pulse at conversion completion |
| result_o | output | RES_BITS | Count of upward decisions from the last conversion |

## Verification
The completion edge of a conversion and a new start request can land in the same clock. The bench raises `start_i` in the cycle just before `done_o` appears, so that the request is sampled on the completing edge. It then holds the comparator high for several iterations. It judges the request ignored if `fb_o` stays low and no further `done_o` pulse appears. A second start pulse in the middle of a conversion must leave the completion time exactly as computed from the first start.

// File: rtl/fic_pkg.sv
package fic_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRE  = 2'd1,
      ST_CONV = 2'd2
   } fic_state_e;
endpackage

// File: rtl/fic_sync.sv
module fic_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] st_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) st_q[0] <= 1'b0;
            else         st_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) st_q[i] <= 1'b0;
            else         st_q[i] <= st_q[i-1];
         end
      end
   end

   assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/fic_iter_timer.sv
module fic_iter_timer #(
   parameter int ITER_CLKS = 13
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic dec_o,
   output logic last_o
);
   localparam int PHW = $clog2(ITER_CLKS);
   localparam logic [PHW-1:0] LAST_PH = PHW'(ITER_CLKS - 1);

   logic [PHW-1:0] phase_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       phase_q <= '0;
      else if (!run_i || phase_q == LAST_PH) phase_q <= '0;
      else                               phase_q <= phase_q + 1'b1;
   end

   assign dec_o  = run_i && (phase_q == '0);
   assign last_o = run_i && (phase_q == LAST_PH);
endmodule

// File: rtl/fic_tally.sv
module fic_tally #(
   parameter int RES_BITS = 14
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                clear_i,
   input  logic                step_i,
   input  logic                up_i,
   input  logic                load_i,
   output logic                carry_o,
   output logic [RES_BITS-1:0] result_o
);
   logic [RES_BITS:0]   total_q;
   logic [RES_BITS:0]   ones_q;
   logic [RES_BITS-1:0] res_q;
   logic [RES_BITS-1:0] clamp_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         total_q <= '0;
         ones_q  <= '0;
      end else if (clear_i) begin
         total_q <= '0;
         ones_q  <= '0;
      end else if (step_i) begin
         total_q <= total_q + 1'b1;
         if (up_i) ones_q <= ones_q + 1'b1;
      end
   end

   assign clamp_w = ones_q[RES_BITS] ? '1 : ones_q[RES_BITS-1:0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     res_q <= '0;
      else if (load_i) res_q <= clamp_w;
   end

   assign carry_o  = total_q[RES_BITS];
   assign result_o = res_q;
endmodule

// File: rtl/fbk_integ_conv.sv
module fbk_integ_conv
   import fic_pkg::*;
#(
   parameter int RES_BITS    = 14,
   parameter int ITER_CLKS   = 13,
   parameter int PRE_ITERS   = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                cmp_i,
   input  logic                start_i,
   input  logic                precharge_i,
   output logic                fb_o,
   output logic                done_o,
   output logic [RES_BITS-1:0] result_o
);
   localparam int PW = (PRE_ITERS > 1) ? $clog2(PRE_ITERS) : 1;

   if (RES_BITS < 2 || RES_BITS > 30) begin : g_bad_res
      $error("RES_BITS out of range");
   end
   if (ITER_CLKS < 2) begin : g_bad_iter
      $error("ITER_CLKS must be at least 2");
   end
   if (PRE_ITERS < 0) begin : g_bad_pre
      $error("PRE_ITERS must not be negative");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   fic_state_e state_q;
   logic cmp_s, dec_w, last_w, busy_w, carry_w;
   logic pre_end_w, pre_req_w, accept_w, finish_w;
   logic fb_q, done_q;

   assign busy_w   = (state_q != ST_IDLE);
   assign accept_w = start_i && (state_q == ST_IDLE);
   assign finish_w = (state_q == ST_CONV) && last_w && carry_w;

   fic_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (cmp_i),
      .q_o   (cmp_s)
   );

   fic_iter_timer #(.ITER_CLKS(ITER_CLKS)) u_timer (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (busy_w),
      .dec_o (dec_w),
      .last_o(last_w)
   );

   fic_tally #(.RES_BITS(RES_BITS)) u_tally (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (accept_w),
      .step_i  (dec_w && (state_q == ST_CONV)),
      .up_i    (cmp_s),
      .load_i  (finish_w),
      .carry_o (carry_w),
      .result_o(result_o)
   );

   if (PRE_ITERS == 0) begin : g_nopre
      assign pre_end_w = 1'b1;
      assign pre_req_w = 1'b0;
   end else begin : g_pre
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                          pre_q <= '0;
         else if (accept_w)                    pre_q <= '0;
         else if (state_q == ST_PRE && last_w) pre_q <= pre_q + 1'b1;
      end
      assign pre_end_w = (pre_q == PW'(PRE_ITERS - 1));
      assign pre_req_w = precharge_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) state_q <= pre_req_w ? ST_PRE : ST_CONV;
            ST_PRE:  if (last_w && pre_end_w) state_q <= ST_CONV;
            ST_CONV: if (finish_w) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fb_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= finish_w;
         if (finish_w)   fb_q <= 1'b0;
         else if (dec_w) fb_q <= cmp_s;
      end
   end

   assign fb_o   = fb_q;
   assign done_o = done_q;
endmodule

// File: rtl/fic_checker.sv
module fic_checker #(
   parameter int RES_BITS = 14
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                fb_o,
   input logic                done_o,
   input logic [RES_BITS-1:0] result_o,
   input logic                cmp_s,
   input logic                dec_w,
   input logic                busy_w
);
   // R7
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R6
   result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable(result_o));

   // R8
   fb_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_w |-> !fb_o);

   // R3
   decide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_w |=> (fb_o == $past(cmp_s)));

   // R2
   fb_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fb_o) |-> $past(dec_w));
endmodule

bind fbk_integ_conv fic_checker #(.RES_BITS(RES_BITS)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .fb_o    (fb_o),
   .done_o  (done_o),
   .result_o(result_o),
   .cmp_s   (cmp_s),
   .dec_w   (dec_w),
   .busy_w  (busy_w)
);

// File: tb/fbk_integ_conv_test.sv
module fbk_integ_conv_test;
   localparam int RB = 8;
   localparam int K  = 6;
   localparam int P  = 100;
   localparam int NITER = 1 << RB;
   localparam real ALPHA = 0.01;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, pre = 1'b0;
   logic drv_cmp = 1'b0, mdl_cmp = 1'b0, use_model = 1'b0;
   logic cmp;
   logic fb, done;
   logic [RB-1:0] res;

   int nchk = 0, nfail = 0;
   real f_lvl = 0.0, x_lvl = 0.5;

   always #5 clk = ~clk;
   assign cmp = use_model ? mdl_cmp : drv_cmp;

   fbk_integ_conv #(.RES_BITS(RB), .ITER_CLKS(K), .PRE_ITERS(P), .SYNC_STAGES(2)) uut (
      .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .start_i(start),
      .precharge_i(pre), .fb_o(fb), .done_o(done), .result_o(res));

   // RC filter model driven by the feedback bit
   always @(negedge clk) begin
      f_lvl = f_lvl + ALPHA * ((fb ? 1.0 : 0.0) - f_lvl);
      mdl_cmp = (x_lvl > f_lvl);
   end

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_near(input string tag, input int act, input int exp, input int tol);
      nchk++;
      if (act > exp + tol || act < exp - tol) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d+-%0d", tag, act, exp, tol);
      end
   endtask

   function automatic int conv_len(input bit with_pre);
      return ((with_pre ? P : 0) + NITER) * K;
   endfunction

   function automatic int ones_for_drop(input int j);
      return j + 1;
   endfunction

   // Runs one conversion; edge 0 is the edge that accepts start.
   task automatic run_conv(input bit with_pre, input int drop_at, input int mid_start,
                           input int probe_at, output int edges, output int probe_fb);
      @(negedge clk);
      start = 1'b1; pre = with_pre;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      edges = 0;
      probe_fb = -1;
      while (edges < 4 * NITER * K) begin
         @(posedge clk);
         edges++;
         @(negedge clk);
         start = (edges == mid_start);
         if (edges == drop_at) drv_cmp = 1'b0;
         if (edges == probe_at) probe_fb = int'(fb);
         if (done) break;
      end
      start = 1'b0;
   endtask

   initial begin
      int e, pf, j, r0, expo;
      int seed = 32'h5EED;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 fb", int'(fb), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 result", int'(res), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R5 comparator held low: zero result, R4 length without precharge
      drv_cmp = 1'b0;
      run_conv(1'b0, -1, -1, -1, e, pf);
      chk("R4 length", e, conv_len(1'b0));
      chk("R5 all low", int'(res), 0);
      chk("R8 fb at done", int'(fb), 0);
      r0 = int'(res);
      @(negedge clk);
      chk("R7 done low next", int'(done), 0);
      chk("R6 hold", int'(res), r0);

      // R5 comparator held high: clamped maximum; R3 fb high mid-run
      drv_cmp = 1'b1;
      run_conv(1'b0, -1, -1, 100, e, pf);
      chk("R3 fb up", pf, 1);
      chk("R5 all high clamp", int'(res), NITER - 1);

      // R3/R5 random drop points, exact count
      for (int i = 0; i < 6; i++) begin
         j = int'($urandom_range(0, 250));
         drv_cmp = 1'b1;
         run_conv(1'b0, j * K + 2, -1, (j + 2) * K + 3, e, pf);
         chk("R5 drop count", int'(res), ones_for_drop(j));
         chk("R3 fb down after drop", pf, 0);
         chk("R2 R4 length", e, conv_len(1'b0));
      end

      // R9 precharge sees 1, counting sees 0; R4 with precharge
      drv_cmp = 1'b1;
      run_conv(1'b1, (P - 1) * K + 2, -1, 300, e, pf);
      chk("R9 fb in precharge", pf, 1);
      chk("R9 precharge not counted", int'(res), 0);
      chk("R4 length pre", e, conv_len(1'b1));

      // R10 start in the middle is ignored
      drv_cmp = 1'b0;
      run_conv(1'b0, -1, 50, -1, e, pf);
      chk("R10 mid start length", e, conv_len(1'b0));

      // R10 start landing on the completing edge is ignored
      drv_cmp = 1'b1;
      run_conv(1'b0, -1, conv_len(1'b0) - 1, -1, e, pf);
      chk("R10 edge length", e, conv_len(1'b0));
      begin
         int seen_fb = 0, seen_done = 0;
         for (int c = 0; c < 4 * K; c++) begin
            @(negedge clk);
            if (fb) seen_fb++;
            if (done) seen_done++;
         end
         chk("R10 no restart fb", seen_fb, 0);
         chk("R10 no restart done", seen_done, 0);
      end

      // R11 closed loop, mid-scale first then random levels
      use_model = 1'b1;
      for (int i = 0; i < 5; i++) begin
         x_lvl = (i == 0) ? 0.5 : 0.15 + 0.7 * (real'($urandom_range(0, 1000)) / 1000.0);
         run_conv(1'b1, -1, -1, -1, e, pf);
         expo = int'(x_lvl * real'(NITER));
         chk_near("R11 closed loop", int'(res), expo, 8);
      end
      use_model = 1'b0;

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule